// File: doc/BRIEF.md
# DAC Output Protection Sequencer

This block decides when a precision DAC may drive its output pin. It owns two digital enables: a pass gate between the output amplifier and the pin, and a clamp that ties the pin to analog ground. The two are always opposite, so the amplifier is never shorted into the clamp. The clamp engages whenever the supply monitor reports a fault or the active-low external reset is pulled low. It is released only after a fresh data word has been latched while both of those conditions are healthy. Releasing the reset or recovering the supplies does not release the clamp by itself.

The block also times the deglitch window of the output track-and-hold. Each falling edge of the load strobe puts the buffer into hold for a fixed number of clock cycles, derived from the clock frequency and a hold time in nanoseconds. In auto-update mode no hold window is produced. The synchronized supply-monitor state is exported as a reset-out flag for other parts of the system. The supply-good and external reset inputs are asynchronous and pass through multi-flop synchronizers. The latch and load strobes come from logic on the same clock.

Top module: `dac_outguard`

## Requirements
- R1: `pass_en_o` and `clamp_en_o` are complements of each other in every cycle. While `rst_n` is low they read pass 0, clamp 1, `hold_o` 0 and `rst_flag_o` 1.
- R2: When `supply_ok_i` goes low, the pass gate stays as it was for the second clock edge and opens, with the clamp closed, at the third edge (two synchronizer flops plus one register).
- R3: After a fault clears, the output stays clamped until `word_latched_i` is sampled high while supplies are good and external reset is high. At the edge that samples the strobe, the pass gate closes and the clamp opens.
- R4: Driving `ext_rst_n_i` low clamps the output at the third clock edge, whatever the supply state.
- R5: A latch strobe sampled while the synchronized external reset is low is discarded, including a strobe that arrives in the very cycle the reset first takes effect. Raising the reset afterwards leaves the output clamped.
- R6: With `auto_upd_i` low, a falling edge on `load_n_i` (1 in one sampled cycle, 0 in the next) raises `hold_o` from the following edge for exactly HOLD cycles. HOLD = CLK_HZ × HOLD_NS / 10^9.
- R7: A new falling edge of `load_n_i` during a hold restarts the count, so `hold_o` stays high for HOLD cycles after the latest edge.
- R8: With `auto_upd_i` high, falling edges of `load_n_i` produce no hold.
- R9: `rst_flag_o` is 1 while the synchronized supply-good is low and 0 otherwise, with three edges of latency from `supply_ok_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| supply_ok_i | input | 1 | Asynchronous supply-good from the voltage monitor |
| ext_rst_n_i | input | 1 | Asynchronous active-low external reset |
| word_latched_i | input | 1 | One-cycle pulse: a new word was written to the DAC latch |
| load_n_i | input | 1 | Active-low load strobe; its falling edge starts a hold |
| auto_upd_i | input | 1 | 1 selects auto-update mode (no hold window) |
| pass_en_o | output | 1 | Enable of the series gate between amplifier and pin |
| clamp_en_o | output | 1 | Enable of the gate tying the pin to ground |
| hold_o | output | 1 | Output buffer in hold mode |
| rst_flag_o | output | 1 | Supply fault flag exported to the system |

## Verification
The critical collision is a latch strobe that reaches the arming logic in the same cycle as a newly synchronized external-reset assertion. The fault must win, and the strobe must not be remembered. The bench provokes this from the clamped, unarmed state. It lowers the reset input and pulses the strobe exactly two cycles later, so both land on the same edge. It then checks that the pass gate stays open, and that it is still open after the reset is released. A second overlap restarts the hold counter part way through a running window. The bench judges this by where the window ends.

// File: rtl/dog_pkg.sv
package dog_pkg;

   typedef struct packed {
      logic pass;
      logic clamp;
   } gate_t;

   localparam gate_t GATE_SAFE = '{pass: 1'b0, clamp: 1'b1};

   function automatic int hold_cycles(input longint clk_hz, input longint hold_ns);
      return int'((clk_hz * hold_ns) / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/dog_sync.sv
module dog_sync #(
   parameter int  STAGES  = 2,
   parameter bit  RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dog_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RST_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dog_arm.sv
module dog_arm
   import dog_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  supply_ok,
   input  logic  ext_ok,
   input  logic  word_latched,
   output gate_t gates_o
);
   gate_t gates_q;
   logic  healthy;
   logic  drive_next;

   always_comb begin
      healthy    = supply_ok & ext_ok;
      drive_next = healthy & (gates_q.pass | word_latched);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gates_q <= GATE_SAFE;
      end else begin
         gates_q.pass  <= drive_next;
         gates_q.clamp <= ~drive_next;
      end
   end

   assign gates_o = gates_q;

   AST_GATES_OPPOSITE: assert property (@(posedge clk) disable iff (!rst_n)
      gates_q.pass ^ gates_q.clamp);                                   // R1
   AST_SUPPLY_FAULT_CLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_ok |=> (gates_q.clamp && !gates_q.pass));                // R2
   AST_EXT_RESET_CLAMPS: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_ok |=> !gates_q.pass);                                      // R4
   AST_ARM_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (!gates_q.pass && !word_latched) |=> !gates_q.pass);             // R3
endmodule

// File: rtl/dog_hold.sv
module dog_hold #(
   parameter int HOLD_CYCLES = 250,
   parameter bit RETRIGGER   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_n,
   input  logic auto_upd,
   output logic hold_o
);
   localparam int CW = $clog2(HOLD_CYCLES + 1);

   if (HOLD_CYCLES < 1) begin : g_bad_hold
      $error("dog_hold: HOLD_CYCLES must be at least 1");
   end

   logic          load_d;
   logic          fall;
   logic          start;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_next;
   logic          hold_q;

   assign fall = load_d & ~load_n;

   if (RETRIGGER) begin : g_restart
      assign start = fall & ~auto_upd;
   end else begin : g_ignore
      assign start = fall & ~auto_upd & (cnt_q == '0);
   end

   always_comb begin
      if (start)              cnt_next = CW'(HOLD_CYCLES);
      else if (cnt_q != '0)   cnt_next = cnt_q - 1'b1;
      else                    cnt_next = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_d <= 1'b1;
         cnt_q  <= '0;
         hold_q <= 1'b0;
      end else begin
         load_d <= load_n;
         cnt_q  <= cnt_next;
         hold_q <= (cnt_next != '0);
      end
   end

   assign hold_o = hold_q;

   AST_HOLD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (load_d && !load_n && !auto_upd) |=> hold_q);                    // R6
   AST_NO_HOLD_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_upd && !hold_q) |=> !hold_q);                              // R8
endmodule

// File: rtl/dac_outguard.sv
module dac_outguard
   import dog_pkg::*;
#(
   parameter longint CLK_HZ      = 50_000_000,
   parameter longint HOLD_NS     = 5000,
   parameter int     SYNC_STAGES = 2,
   parameter bit     RETRIGGER   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok_i,
   input  logic ext_rst_n_i,
   input  logic word_latched_i,
   input  logic load_n_i,
   input  logic auto_upd_i,
   output logic pass_en_o,
   output logic clamp_en_o,
   output logic hold_o,
   output logic rst_flag_o
);
   localparam int HOLD_CYCLES = hold_cycles(CLK_HZ, HOLD_NS);

   logic  supply_s;
   logic  ext_s;
   gate_t gates;
   logic  flag_q;

   dog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_supply (
      .clk(clk), .rst_n(rst_n), .d_i(supply_ok_i), .q_o(supply_s));

   dog_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .d_i(ext_rst_n_i), .q_o(ext_s));

   dog_arm u_arm (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_s), .ext_ok(ext_s),
      .word_latched(word_latched_i), .gates_o(gates));

   dog_hold #(.HOLD_CYCLES(HOLD_CYCLES), .RETRIGGER(RETRIGGER)) u_hold (
      .clk(clk), .rst_n(rst_n), .load_n(load_n_i), .auto_upd(auto_upd_i),
      .hold_o(hold_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b1;
      else        flag_q <= ~supply_s;
   end

   assign pass_en_o  = gates.pass;
   assign clamp_en_o = gates.clamp;
   assign rst_flag_o = flag_q;

   AST_FLAG_TRACKS_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
      supply_s |=> !flag_q);                                           // R9
   AST_FLAG_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      !supply_s |=> (flag_q && !pass_en_o));                           // R9
endmodule

// File: tb/dac_outguard_test.sv
module dac_outguard_test;
   localparam int HOLD = 8;            // 50 MHz x 160 ns
   localparam int S_PASS = 0, S_CLAMP = 1, S_HOLD = 2, S_FLAG = 3;

   typedef struct {
      int    due;
      int    sig;
      logic  val;
      string req;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n, supply_ok, ext_rst_n, word_latched, load_n, auto_upd;
   logic pass_en, clamp_en, hold, rst_flag;

   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sbq[$];

   always #10 clk = ~clk;

   dac_outguard #(.CLK_HZ(50_000_000), .HOLD_NS(160)) uut (
      .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok), .ext_rst_n_i(ext_rst_n),
      .word_latched_i(word_latched), .load_n_i(load_n), .auto_upd_i(auto_upd),
      .pass_en_o(pass_en), .clamp_en_o(clamp_en), .hold_o(hold), .rst_flag_o(rst_flag));

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   function automatic logic pick(int sig);
      case (sig)
         S_PASS:  return pass_en;
         S_CLAMP: return clamp_en;
         S_HOLD:  return hold;
         default: return rst_flag;
      endcase
   endfunction

   task automatic check_now(int sig, logic val, string req);
      logic act = pick(sig);
      n_run++;
      if (act !== val) begin
         n_fail++;
         $display("FAIL %s sig=%0d actual=%0b expected=%0b cycle=%0d", req, sig, act, val, cyc);
      end
   endtask

   // driver side: expectation due 'dly' edges after the current negedge
   task automatic expect_at(int dly, int sig, logic val, string req);
      exp_t e;
      e.due = cyc + dly; e.sig = sig; e.val = val; e.req = req;
      sbq.push_back(e);
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compares scoreboard items at their due cycle
   always @(negedge clk) begin
      if (rst_n) begin
         for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due == cyc) begin
               check_now(sbq[i].sig, sbq[i].val, sbq[i].req);
               sbq.delete(i);
            end
         end
      end
   end

   task automatic pulse_latch();
      word_latched = 1'b1;
      step(1);
      word_latched = 1'b0;
   endtask

   initial begin
      rst_n = 1'b0; supply_ok = 1'b0; ext_rst_n = 1'b0;
      word_latched = 1'b0; load_n = 1'b1; auto_upd = 1'b0;
      step(3);
      check_now(S_PASS, 1'b0, "R1 reset");
      check_now(S_CLAMP, 1'b1, "R1 reset");
      check_now(S_HOLD, 1'b0, "R1 reset");
      check_now(S_FLAG, 1'b1, "R1 reset");
      rst_n = 1'b1;
      step(2);

      // R3: supplies good and reset high, but no word yet
      supply_ok = 1'b1; ext_rst_n = 1'b1;
      expect_at(2, S_FLAG, 1'b1, "R9 latency");
      expect_at(3, S_FLAG, 1'b0, "R9");
      expect_at(5, S_PASS, 1'b0, "R3 no word");
      step(6);
      word_latched = 1'b1;
      expect_at(1, S_PASS, 1'b1, "R3 word arms");
      expect_at(1, S_CLAMP, 1'b0, "R1");
      step(1); word_latched = 1'b0; step(3);

      // R2: supply fault
      supply_ok = 1'b0;
      expect_at(2, S_PASS, 1'b1, "R2 latency");
      expect_at(3, S_PASS, 1'b0, "R2");
      expect_at(3, S_CLAMP, 1'b1, "R2");
      expect_at(3, S_FLAG, 1'b1, "R9 fault");
      step(6);
      supply_ok = 1'b1;
      step(6);
      expect_at(1, S_PASS, 1'b0, "R3 recovery alone");
      expect_at(1, S_FLAG, 1'b0, "R9 recovered");
      step(2);

      // R5: strobe lands in the cycle the synchronized reset first drops
      ext_rst_n = 1'b0;
      step(2);
      word_latched = 1'b1;
      expect_at(1, S_PASS, 1'b0, "R5 same-cycle");
      step(1); word_latched = 1'b0;
      step(2);
      pulse_latch();
      ext_rst_n = 1'b1;
      step(5);
      expect_at(1, S_PASS, 1'b0, "R5 release alone");
      expect_at(1, S_CLAMP, 1'b1, "R5 release alone");
      step(2);
      word_latched = 1'b1;
      expect_at(1, S_PASS, 1'b1, "R3 reload");
      step(1); word_latched = 1'b0; step(2);

      // R4: external reset with good supplies
      ext_rst_n = 1'b0;
      expect_at(2, S_PASS, 1'b1, "R4 latency");
      expect_at(3, S_PASS, 1'b0, "R4");
      expect_at(3, S_CLAMP, 1'b1, "R4");
      expect_at(3, S_FLAG, 1'b0, "R9 unaffected");
      step(5);
      ext_rst_n = 1'b1;
      step(4);
      pulse_latch();
      step(2);

      // R6: hold window length
      load_n = 1'b0;
      expect_at(1, S_HOLD, 1'b1, "R6 start");
      expect_at(HOLD, S_HOLD, 1'b1, "R6 last");
      expect_at(HOLD + 1, S_HOLD, 1'b0, "R6 end");
      expect_at(1, S_PASS, 1'b1, "R6 gates unaffected");
      step(2); load_n = 1'b1;
      step(HOLD + 3);

      // R7: retrigger inside the window
      load_n = 1'b0;
      step(1); load_n = 1'b1;
      step(3);
      load_n = 1'b0;
      expect_at(HOLD - 3, S_HOLD, 1'b1, "R7 past first window");
      expect_at(HOLD, S_HOLD, 1'b1, "R7 last");
      expect_at(HOLD + 1, S_HOLD, 1'b0, "R7 end");
      step(2); load_n = 1'b1;
      step(HOLD + 3);

      // R8: auto-update mode, strobe held low
      auto_upd = 1'b1;
      step(1);
      load_n = 1'b0;
      expect_at(1, S_HOLD, 1'b0, "R8");
      expect_at(3, S_HOLD, 1'b0, "R8");
      step(6);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
            step(2);
         end
         begin
            repeat (20000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      if (sbq.size() != 0) begin
         n_run++;
         n_fail++;
         $display("FAIL scoreboard actual=%0d expected=0 pending", sbq.size());
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule